// File: doc/BRIEF.md
# Flash Block Protection Controller

This block holds the write-protection state of a parallel NOR flash array made of uniform blocks and decides, for each access, whether the addressed block may be read, programmed or erased. Each block carries two stored protection bits. The volatile bit is lost at power-on. The persistent bit keeps its value through both resets and is modelled with flops that no reset touches. A lock bit freezes the persistent bits until the next power-on. A one-time bit protects the extended block.

Two pin levels act on top of the stored state. An active-low write-protect pin forces protection onto the outermost block, which is the top block or the bottom block as set by a build parameter. A high-voltage unprotect input lifts the stored protection of every block. A build option adds a password gate: until the matching password has been presented, the block denies every access and ignores every other command. The deny output is combinational, so the answer for the block on `req_blk` appears in the same cycle.

Top module: `flash_prot_ctrl`

## Requirements
- R1: After power-on, with `wp_n` high, `hv_unprot` low, no password gate, and the persistent bits never set, `access_deny` is 0 for every block and for the extended block.
- R2: The command op 1 sets the volatile bit of `req_blk` and op 2 clears it. From the next cycle, `access_deny` is 1 for that block only while the bit is set.
- R3: Volatile bits are cleared when `por_n` is low. They keep their value through a low pulse on `rst_n`.
- R4: Op 3 sets the persistent bit of `req_blk` and op 4 clears all persistent bits at once. The persistent bits keep their value through low pulses on both `por_n` and `rst_n`.
- R5: Op 5 sets the lock bit. While the lock bit is set, ops 3 and 4 are ignored. Only a low `por_n` clears the lock bit.
- R6: While `wp_n` is low, `access_deny` is 1 for the outermost block: block NUM_BLOCKS-1 when WP_TOP=1 and block 0 when WP_TOP=0. When `wp_n` returns high, that block follows its stored bits again, including changes made while the pin was low.
- R7: While `hv_unprot` is high and the lock bit is clear, blocks protected only by stored bits are allowed. The input has no effect while the lock bit is set, and it does not lift the protection that `wp_n` applies.
- R8: Op 7 sets the extended-block protect bit. While `req_ext` is 1, `access_deny` reports that bit. Nothing clears the bit, including `por_n`.
- R9: With PW_MODE=1, `access_deny` is 1 and every op except op 6 is ignored until op 6 presents a `req_pw` equal to PASSWORD. A wrong password has no effect, and a low pulse on `rst_n` or `por_n` gates the block again.
- R10: With PW_MODE=1, `hv_unprot` has no effect until the correct password has been presented.
- R11: `access_deny` follows `req_blk` and `req_ext` in the same cycle. Op 0 with `req_valid` high is a plain access and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on event, active low, asynchronous |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| wp_n | input | 1 | Write-protect pin level, low protects the outermost block |
| hv_unprot | input | 1 | High-voltage temporary unprotect level |
| req_valid | input | 1 | Command strobe |
| req_op | input | 3 | Command code: 0 access, 1 volatile set, 2 volatile clear, 3 persistent set, 4 persistent clear-all, 5 lock, 6 password, 7 extended protect |
| req_blk | input | BLK_W | Block index for the command and the deny query |
| req_ext | input | 1 | Query targets the extended block |
| req_pw | input | PW_W | Password presented with op 6 |
| access_deny | output | 1 | 1 when the addressed block may not be accessed |

## Verification
The bench builds two instances from the same stimulus. The first uses WP_TOP=1 and PW_MODE=0, which exercises top-block write protect and the unguarded command paths. The second uses WP_TOP=0 and PW_MODE=1 with a fixed 64-bit password, which brings bottom-block write protect, the rejection of a wrong password, the ignoring of commands while gated, and the re-gating by reset within reach. The default of 256 blocks is kept, so the extreme indices 0 and 255 are both checked.

// File: rtl/flash_prot_ctrl.sv
module flash_prot_ctrl #(
  parameter int NUM_BLOCKS = 256,
  parameter int PW_W = 64,
  parameter bit WP_TOP = 1'b1,
  parameter bit PW_MODE = 1'b0,
  parameter logic [PW_W-1:0] PASSWORD = '0,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             wp_n,
  input  logic             hv_unprot,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [BLK_W-1:0] req_blk,
  input  logic             req_ext,
  input  logic [PW_W-1:0]  req_pw,
  output logic             access_deny
);

  localparam logic [2:0] OP_ACCESS = 3'd0;
  localparam logic [2:0] OP_VSET   = 3'd1;
  localparam logic [2:0] OP_VCLR   = 3'd2;
  localparam logic [2:0] OP_NSET   = 3'd3;
  localparam logic [2:0] OP_NCLR   = 3'd4;
  localparam logic [2:0] OP_LOCK   = 3'd5;
  localparam logic [2:0] OP_PASS   = 3'd6;
  localparam logic [2:0] OP_EXT    = 3'd7;
  localparam logic [BLK_W-1:0] OUTER_IDX = WP_TOP ? BLK_W'(NUM_BLOCKS - 1) : '0;

  logic [NUM_BLOCKS-1:0] vol_q;
  logic [NUM_BLOCKS-1:0] nv_q = '0;
  logic                  ext_q = 1'b0;
  logic                  lock_q;
  logic                  unlocked_q;

  wire gated   = PW_MODE && !unlocked_q;
  wire cmd_ok  = req_valid && !gated;
  wire nv_ok   = cmd_ok && !lock_q;
  wire hv_on   = hv_unprot && !lock_q && !gated;
  wire wp_hit  = !wp_n && (req_blk == OUTER_IDX);
  wire stored  = vol_q[req_blk] | nv_q[req_blk];

  assign access_deny = gated | (req_ext ? ext_q : (wp_hit | (stored & ~hv_on)));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      vol_q  <= '0;
      lock_q <= 1'b0;
    end else if (cmd_ok) begin
      if (req_op == OP_VSET) vol_q[req_blk] <= 1'b1;
      if (req_op == OP_VCLR) vol_q[req_blk] <= 1'b0;
      if (req_op == OP_LOCK) lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (por_n && nv_ok) begin
      if (req_op == OP_NSET) nv_q[req_blk] <= 1'b1;
      if (req_op == OP_NCLR) nv_q <= '0;
    end
    if (por_n && cmd_ok && req_op == OP_EXT) ext_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge por_n or negedge rst_n) begin
    if (!por_n || !rst_n) unlocked_q <= 1'b0;
    else if (req_valid && req_op == OP_PASS && req_pw == PASSWORD) unlocked_q <= 1'b1;
  end

  a_r5_lock_freezes_nv: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    lock_q |=> $stable(nv_q));

  a_r6_wp_outer: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (!wp_n && !req_ext && req_blk == OUTER_IDX) |-> access_deny);

  a_r8_ext_sticky: assert property (@(posedge clk) disable iff (!por_n)
    ext_q |=> ext_q);

  a_r9_pw_gate: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (PW_MODE && !unlocked_q) |-> access_deny);

  a_r2_vol_set: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (cmd_ok && req_op == OP_VSET) |=> vol_q[$past(req_blk)]);

  a_r11_access_no_change: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (req_valid && req_op == OP_ACCESS) |=> ($stable(vol_q) && $stable(nv_q) && $stable(lock_q)));

  a_r7_hv_lifts: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (hv_unprot && !lock_q && !gated && wp_n && !req_ext) |-> !access_deny);

endmodule

// File: tb/tb_flash_prot_ctrl.sv
module tb_flash_prot_ctrl;
  localparam logic [63:0] PW = 64'hC0DE_5EED_1234_ABCD;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b1, wp_n = 1'b1, hv_unprot = 1'b0;
  logic req_valid = 1'b0, req_ext = 1'b0;
  logic [2:0] req_op = '0;
  logic [7:0] req_blk = '0;
  logic [63:0] req_pw = '0;
  logic deny_a, deny_b;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  flash_prot_ctrl #(.NUM_BLOCKS(256), .PW_W(64), .WP_TOP(1'b1), .PW_MODE(1'b0)) dut (
    .clk, .por_n, .rst_n, .wp_n, .hv_unprot, .req_valid, .req_op, .req_blk,
    .req_ext, .req_pw, .access_deny(deny_a));

  flash_prot_ctrl #(.NUM_BLOCKS(256), .PW_W(64), .WP_TOP(1'b0), .PW_MODE(1'b1), .PASSWORD(PW)) dut_pw (
    .clk, .por_n, .rst_n, .wp_n, .hv_unprot, .req_valid, .req_op, .req_blk,
    .req_ext, .req_pw, .access_deny(deny_b));

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cmd(logic [2:0] op, logic [7:0] blk, logic [63:0] pw = '0);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_blk = blk; req_pw = pw;
    @(negedge clk);
    req_valid = 1'b0; req_op = '0;
  endtask

  task automatic qa(string req, logic [7:0] blk, logic exp);
    req_ext = 1'b0; req_blk = blk; #1;
    chk(req, deny_a, exp);
  endtask

  task automatic qb(string req, logic [7:0] blk, logic exp);
    req_ext = 1'b0; req_blk = blk; #1;
    chk(req, deny_b, exp);
  endtask

  task automatic pulse_por();
    @(negedge clk); por_n = 1'b0; @(negedge clk); por_n = 1'b1; @(negedge clk);
  endtask

  task automatic pulse_rst();
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
  endtask

  task automatic t_reset();
    pulse_por();
    qa("R1", 8'd0, 1'b0); qa("R1", 8'd100, 1'b0); qa("R1", 8'd255, 1'b0);
    req_ext = 1'b1; #1; chk("R1 ext", deny_a, 1'b0); req_ext = 1'b0;
    qb("R9 gated after power-on", 8'd5, 1'b1);
  endtask

  task automatic t_vol();
    cmd(3'd1, 8'd10);
    qa("R2 set", 8'd10, 1'b1); qa("R2 neighbour", 8'd11, 1'b0);
    req_blk = 8'd11; #1; chk("R11 same-cycle", deny_a, 1'b0);
    req_blk = 8'd10; #1; chk("R11 same-cycle", deny_a, 1'b1);
    cmd(3'd2, 8'd10);
    qa("R2 clear", 8'd10, 1'b0);
    cmd(3'd1, 8'd20);
    cmd(3'd0, 8'd20);
    qa("R11 access op", 8'd20, 1'b1);
    pulse_rst();
    qa("R3 kept over rst_n", 8'd20, 1'b1);
    pulse_por();
    qa("R3 lost at power-on", 8'd20, 1'b0);
  endtask

  task automatic t_nv();
    cmd(3'd3, 8'd30);
    qa("R4 set", 8'd30, 1'b1);
    pulse_rst();
    qa("R4 kept over rst_n", 8'd30, 1'b1);
    pulse_por();
    qa("R4 kept over por_n", 8'd30, 1'b1);
    cmd(3'd4, 8'd0);
    qa("R4 clear-all", 8'd30, 1'b0);
  endtask

  task automatic t_lock();
    cmd(3'd3, 8'd40);
    cmd(3'd5, 8'd0);
    cmd(3'd4, 8'd0);
    qa("R5 clear ignored", 8'd40, 1'b1);
    cmd(3'd3, 8'd41);
    qa("R5 set ignored", 8'd41, 1'b0);
    hv_unprot = 1'b1;
    qa("R7 no effect when locked", 8'd40, 1'b1);
    hv_unprot = 1'b0;
    pulse_por();
    cmd(3'd4, 8'd0);
    qa("R5 lock gone after power-on", 8'd40, 1'b0);
  endtask

  task automatic t_wp();
    wp_n = 1'b0;
    qa("R6 top forced", 8'd255, 1'b1); qa("R6 other free", 8'd254, 1'b0);
    qb("R6 bench gate", 8'd0, 1'b1);
    wp_n = 1'b1;
    qa("R6 released", 8'd255, 1'b0);
    cmd(3'd1, 8'd255);
    wp_n = 1'b0;
    cmd(3'd2, 8'd255);
    qa("R6 still forced", 8'd255, 1'b1);
    hv_unprot = 1'b1;
    qa("R7 does not lift pin", 8'd255, 1'b1);
    hv_unprot = 1'b0;
    wp_n = 1'b1;
    qa("R6 reverts to stored", 8'd255, 1'b0);
  endtask

  task automatic t_hv();
    cmd(3'd1, 8'd50);
    cmd(3'd3, 8'd51);
    hv_unprot = 1'b1;
    qa("R7 volatile lifted", 8'd50, 1'b0); qa("R7 persistent lifted", 8'd51, 1'b0);
    hv_unprot = 1'b0;
    qa("R7 volatile back", 8'd50, 1'b1); qa("R7 persistent back", 8'd51, 1'b1);
    cmd(3'd2, 8'd50);
    cmd(3'd4, 8'd0);
    qa("R4 cleanup", 8'd51, 1'b0);
  endtask

  task automatic t_pw();
    pulse_por();
    cmd(3'd1, 8'd7);
    cmd(3'd6, 8'd0, PW ^ 64'h1);
    qb("R9 wrong password", 8'd9, 1'b1);
    hv_unprot = 1'b1;
    qb("R10 hv while gated", 8'd9, 1'b1);
    hv_unprot = 1'b0;
    cmd(3'd6, 8'd0, PW);
    qb("R9 unlocked", 8'd9, 1'b0);
    qb("R9 gated command ignored", 8'd7, 1'b0);
    cmd(3'd1, 8'd7);
    qb("R9 command after unlock", 8'd7, 1'b1);
    hv_unprot = 1'b1;
    qb("R10 hv after unlock", 8'd7, 1'b0);
    hv_unprot = 1'b0;
    wp_n = 1'b0;
    qb("R6 bottom forced", 8'd0, 1'b1); qb("R6 bottom other", 8'd1, 1'b0);
    wp_n = 1'b1;
    pulse_rst();
    qb("R9 regated by rst_n", 8'd9, 1'b1);
  endtask

  task automatic t_ext();
    pulse_por();
    cmd(3'd2, 8'd7);
    req_ext = 1'b1; #1; chk("R8 ext open", deny_a, 1'b0);
    cmd(3'd7, 8'd0);
    req_ext = 1'b1; #1; chk("R8 ext protected", deny_a, 1'b1);
    qa("R8 array unaffected", 8'd60, 1'b0);
    pulse_por();
    req_ext = 1'b1; #1; chk("R8 survives power-on", deny_a, 1'b1);
    req_ext = 1'b0;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_vol();
    t_nv();
    t_lock();
    t_wp();
    t_hv();
    t_pw();
    t_ext();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule